// File: doc/BRIEF.md
# Bus Arbitration Controller

This block decides when the local bus master hands the shared external bus to another device. An outside requester raises a bus request; the controller answers with a bus grant once its own traffic allows it. The requester confirms it has taken the bus by raising grant-acknowledge, and it keeps the bus for as long as that acknowledge stays high. Both handshake inputs arrive asynchronously, so the block passes them through its own synchronizers before using them.

The grant is held back while the local master is inside a multi-cycle operand transfer, stopping at the cycle that ends the transfer. It is also held back while a locked read-modify-write sequence is running, and at all times while the show-cycle mode selects the value that forbids external mastership. A separate three-state request tells the pad logic to release the address, data and control buses. The pads actually float only on the first clock edge at which the local address strobe and the lock are both low. A request that is still present after the acknowledge arrives is treated as a new request, and the next grant is prepared while the current master still holds the bus.

Top module: `busarb_ctrl`

## Requirements
- R1: While reset is active and on the first sample after reset is released, `grant_o`, `tristate_o` and `bus_float_o` are all 0.
- R2: With the default two synchronizer stages and nothing holding the grant back, `grant_o` rises on the third rising edge after `br_async_i` rises, and not before.
- R3: While `xfer_active_i` is 1 and `xfer_last_i` is 0, `grant_o` does not rise. A pending request is granted on the edge that closes the cycle in which `xfer_last_i` is 1.
- R4: `grant_o` does not rise while `rmw_lock_i` is 1.
- R5: When `show_mode_i` equals 2'b01, `grant_o` never rises. Any other value of `show_mode_i` does not hold the grant back.
- R6: Once the synchronized acknowledge is seen while granting, `grant_o` falls on the next edge and `tristate_o` is 1.
- R7: `bus_float_o` rises only on an edge where `tristate_o` was 1 and both `addr_strobe_i` and `rmw_lock_i` were 0. While `addr_strobe_i` stays 1 the buses do not float.
- R8: When acknowledge is withdrawn with no request pending, `tristate_o` falls, and `bus_float_o` falls one clock after that.
- R9: If the request is still asserted after acknowledge has been seen, `tristate_o` stays 1 while acknowledge is held. When acknowledge is then withdrawn, `grant_o` is reissued without `tristate_o` ever falling.
- R10: If the request is withdrawn while granted and before any acknowledge, `grant_o` falls and `tristate_o` is 0 on the next edge, so the buses never float.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| br_async_i | input | 1 | Bus request from an external device, asynchronous, active high |
| bgack_async_i | input | 1 | Grant acknowledge from the external master, asynchronous, active high |
| xfer_active_i | input | 1 | Local multi-cycle operand transfer in progress |
| xfer_last_i | input | 1 | Current cycle is the final cycle of that transfer |
| rmw_lock_i | input | 1 | Locked read-modify-write sequence in progress |
| addr_strobe_i | input | 1 | Local address strobe, active high |
| show_mode_i | input | 2 | Show-cycle mode; 2'b01 forbids external mastership |
| grant_o | output | 1 | Bus grant to the external device, active high |
| tristate_o | output | 1 | Request to release the address, data and control buses |
| bus_float_o | output | 1 | Buses are in high impedance |

## Verification
Each handshake input changes only 1 ns after a rising edge. A change on it reaches `grant_o` or `tristate_o` on the third edge that follows: two synchronizer edges and one state edge. Changes on the local status inputs reach those outputs on the first edge, and `bus_float_o` follows `tristate_o` one edge later. The vector walk holds each row for six clocks, so every row is compared in a settled state. The directed tests sample 1 ns after exactly the edge counts above, so one edge early or late is reported as a miscompare.

// File: rtl/busarb_pkg.sv
package busarb_pkg;

   // State codes; the values 1 and 4 are deliberately left unused.
   typedef enum logic [2:0] {
      ARB_OWN     = 3'd0,
      ARB_GRANT   = 3'd2,
      ARB_TAKEN   = 3'd3,
      ARB_DROP    = 3'd5,
      ARB_REQUEUE = 3'd6,
      ARB_REGRANT = 3'd7
   } arb_state_e;

   localparam int unsigned ARB_STATE_W = $bits(arb_state_e);

endpackage

// File: rtl/busarb_sync.sv
module busarb_sync #(
   parameter int unsigned STAGES    = 2,
   parameter bit          RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);

   generate
      if (STAGES < 1 || STAGES > 2) begin : g_bad_depth
         $error("busarb_sync: STAGES must be 1 or 2");
      end

      if (STAGES == 1) begin : g_single
         logic stage_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= RESET_VAL;
            else        stage_q <= d_async;
         end
         assign q_sync = stage_q;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
            else        chain_q <= {chain_q[STAGES-2:0], d_async};
         end
         assign q_sync = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/busarb_gate.sv
module busarb_gate #(
   parameter int unsigned        SHOW_W     = 2,
   parameter logic [SHOW_W-1:0]  SHOW_BLOCK = 2'b01,
   parameter bit                 LAST_EARLY = 1'b1
) (
   input  logic              xfer_active,
   input  logic              xfer_last,
   input  logic              rmw_lock,
   input  logic [SHOW_W-1:0] show_mode,
   output logic              grant_ok
);

   logic xfer_hold;

   generate
      if (SHOW_W < 1) begin : g_bad_width
         $error("busarb_gate: SHOW_W must be at least 1");
      end

      if (LAST_EARLY) begin : g_last_early
         // Grant may be latched on the edge that ends the final cycle.
         assign xfer_hold = xfer_active && !xfer_last;
      end else begin : g_last_late
         // Grant waits until the transfer flag itself has dropped.
         assign xfer_hold = xfer_active;
      end
   endgenerate

   always_comb begin
      grant_ok = 1'b1;
      if (xfer_hold)                grant_ok = 1'b0;
      if (rmw_lock)                 grant_ok = 1'b0;
      if (show_mode == SHOW_BLOCK)  grant_ok = 1'b0;
   end

endmodule

// File: rtl/busarb_fsm.sv
module busarb_fsm
   import busarb_pkg::*;
(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req,
   input  logic                   ack,
   input  logic                   grant_ok,
   output logic                   grant,
   output logic                   tri_req,
   output logic [ARB_STATE_W-1:0] state_code
);

   arb_state_e state_q, state_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ARB_OWN;
      else        state_q <= state_d;
   end

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ARB_OWN: begin
            if (req && grant_ok) state_d = ARB_GRANT;
         end
         ARB_GRANT: begin
            if (ack)       state_d = ARB_TAKEN;
            else if (!req) state_d = ARB_OWN;
         end
         ARB_TAKEN: begin
            if (!ack)     state_d = ARB_DROP;
            else if (req) state_d = ARB_REQUEUE;
         end
         ARB_DROP: begin
            state_d = ARB_OWN;
         end
         ARB_REQUEUE: begin
            if (!ack) begin
               if (req && grant_ok) state_d = ARB_REGRANT;
               else                 state_d = ARB_DROP;
            end else if (!req) begin
               state_d = ARB_TAKEN;
            end
         end
         ARB_REGRANT: begin
            if (ack)       state_d = ARB_TAKEN;
            else if (!req) state_d = ARB_DROP;
         end
         default: state_d = ARB_OWN;
      endcase
   end

   assign grant      = (state_q == ARB_GRANT) || (state_q == ARB_REGRANT);
   assign tri_req    = (state_q == ARB_TAKEN) || (state_q == ARB_REQUEUE) ||
                       (state_q == ARB_REGRANT);
   assign state_code = state_q;

endmodule

// File: rtl/busarb_float.sv
module busarb_float (
   input  logic clk,
   input  logic rst_n,
   input  logic tri_req,
   input  logic addr_strobe,
   input  logic rmw_lock,
   output logic bus_float
);

   logic float_q;
   logic local_idle;

   assign local_idle = !addr_strobe && !rmw_lock;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) float_q <= 1'b0;
      else        float_q <= tri_req && (float_q || local_idle);
   end

   assign bus_float = float_q;

endmodule

// File: rtl/busarb_ctrl.sv
module busarb_ctrl
   import busarb_pkg::*;
#(
   parameter int unsigned       SYNC_STAGES = 2,
   parameter int unsigned       SHOW_W      = 2,
   parameter logic [SHOW_W-1:0] SHOW_BLOCK  = 2'b01,
   parameter bit                LAST_EARLY  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              br_async_i,
   input  logic              bgack_async_i,
   input  logic              xfer_active_i,
   input  logic              xfer_last_i,
   input  logic              rmw_lock_i,
   input  logic              addr_strobe_i,
   input  logic [SHOW_W-1:0] show_mode_i,
   output logic              grant_o,
   output logic              tristate_o,
   output logic              bus_float_o
);

   logic                   req_s;
   logic                   ack_s;
   logic                   grant_ok;
   logic [ARB_STATE_W-1:0] state_code;

   busarb_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_req (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (br_async_i),
      .q_sync  (req_s)
   );

   busarb_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_ack (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (bgack_async_i),
      .q_sync  (ack_s)
   );

   busarb_gate #(
      .SHOW_W     (SHOW_W),
      .SHOW_BLOCK (SHOW_BLOCK),
      .LAST_EARLY (LAST_EARLY)
   ) u_gate (
      .xfer_active (xfer_active_i),
      .xfer_last   (xfer_last_i),
      .rmw_lock    (rmw_lock_i),
      .show_mode   (show_mode_i),
      .grant_ok    (grant_ok)
   );

   busarb_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .req        (req_s),
      .ack        (ack_s),
      .grant_ok   (grant_ok),
      .grant      (grant_o),
      .tri_req    (tristate_o),
      .state_code (state_code)
   );

   busarb_float u_float (
      .clk         (clk),
      .rst_n       (rst_n),
      .tri_req     (tristate_o),
      .addr_strobe (addr_strobe_i),
      .rmw_lock    (rmw_lock_i),
      .bus_float   (bus_float_o)
   );

endmodule

// File: rtl/busarb_ctrl_chk.sv
module busarb_ctrl_chk #(
   parameter int unsigned       SHOW_W     = 2,
   parameter logic [SHOW_W-1:0] SHOW_BLOCK = 2'b01
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_s,
   input logic              ack_s,
   input logic              xfer_active,
   input logic              xfer_last,
   input logic              rmw_lock,
   input logic              addr_strobe,
   input logic [SHOW_W-1:0] show_mode,
   input logic              grant,
   input logic              tri_req,
   input logic              bus_float
);

   // R3
   xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(grant) |-> !$past(xfer_active && !xfer_last));

   // R4
   rmw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(grant) |-> !$past(rmw_lock));

   // R5
   show_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(grant) |-> ($past(show_mode) != SHOW_BLOCK));

   // R6
   ack_drops_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && ack_s) |=> (!grant && tri_req));

   // R7
   float_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_float) |-> ($past(tri_req) && !$past(addr_strobe) && !$past(rmw_lock)));

   // R8
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tri_req && !grant && !ack_s && !req_s) |=> !tri_req);

   // R9
   requeue_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tri_req && ack_s && req_s) |=> (tri_req && !grant));

   // R10
   withdraw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && !ack_s && !req_s) |=> (!grant && !tri_req));

endmodule

bind busarb_ctrl busarb_ctrl_chk #(
   .SHOW_W     (SHOW_W),
   .SHOW_BLOCK (SHOW_BLOCK)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_s       (req_s),
   .ack_s       (ack_s),
   .xfer_active (xfer_active_i),
   .xfer_last   (xfer_last_i),
   .rmw_lock    (rmw_lock_i),
   .addr_strobe (addr_strobe_i),
   .show_mode   (show_mode_i),
   .grant       (grant_o),
   .tri_req     (tristate_o),
   .bus_float   (bus_float_o)
);

// File: tb/busarb_ctrl_bench.sv
module busarb_ctrl_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       br = 1'b0, bgack = 1'b0, xfer = 1'b0, last = 1'b0;
   logic       rmw = 1'b0, as_i = 1'b0;
   logic [1:0] show = 2'b00;
   logic       grant, tri_o, flt;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   busarb_ctrl u_busarb_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .br_async_i    (br),
      .bgack_async_i (bgack),
      .xfer_active_i (xfer),
      .xfer_last_i   (last),
      .rmw_lock_i    (rmw),
      .addr_strobe_i (as_i),
      .show_mode_i   (show),
      .grant_o       (grant),
      .tristate_o    (tri_o),
      .bus_float_o   (flt)
   );

   // Row: {br, bgack, xfer, last, rmw, as, show[1:0], grant, tristate, float}
   localparam int NV = 17;
   localparam logic [10:0] VEC [NV] = '{
      11'b0_0_0_0_0_0_00_000,  //  0 idle                   R1
      11'b1_0_0_0_0_1_00_100,  //  1 request granted        R2
      11'b0_1_0_0_0_1_00_010,  //  2 ack, strobe held       R6 R7
      11'b0_1_0_0_0_0_00_011,  //  3 strobe low, float      R7
      11'b0_0_0_0_0_0_00_000,  //  4 ack gone               R8
      11'b1_0_0_0_1_0_00_000,  //  5 lock holds grant       R4
      11'b1_0_0_0_0_0_00_100,  //  6 lock gone              R4
      11'b0_0_0_0_0_0_00_000,  //  7 withdraw               R10
      11'b1_0_0_0_0_0_01_000,  //  8 show 01 blocks         R5
      11'b1_0_0_0_0_0_10_100,  //  9 show 10 allows         R5
      11'b0_0_0_0_0_0_10_000,  // 10 withdraw               R10
      11'b1_0_1_0_0_0_00_000,  // 11 transfer holds         R3
      11'b1_0_0_0_0_0_00_100,  // 12 transfer done          R3
      11'b1_1_0_0_0_0_00_011,  // 13 req kept after ack     R9
      11'b1_0_0_0_0_0_00_111,  // 14 regrant while floated  R9
      11'b0_1_0_0_0_0_00_011,  // 15 new master acks        R9
      11'b0_0_0_0_0_0_00_000   // 16 released               R8
   };

   function automatic string row_req(input int i);
      case (i)
         0: return "R1";
         1: return "R2";
         2, 3: return "R7";
         4, 16: return "R8";
         5, 6: return "R4";
         7, 10: return "R10";
         8, 9: return "R5";
         11, 12: return "R3";
         default: return "R9";
      endcase
   endfunction

   task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: {grant,tristate,float} actual %b expected %b at %0t",
                  req, got, exp, $time);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic idle_inputs();
      br = 0; bgack = 0; xfer = 0; last = 0; rmw = 0; as_i = 0; show = 2'b00;
   endtask

   initial begin
      // R1: state during and after reset
      #3;
      check("R1", {grant, tri_o, flt}, 3'b000);
      tick(2);
      rst_n = 1'b1;
      tick(1);
      check("R1", {grant, tri_o, flt}, 3'b000);

      for (int i = 0; i < NV; i++) begin
         {br, bgack, xfer, last, rmw, as_i, show} = VEC[i][10:3];
         tick(6);
         check(row_req(i), {grant, tri_o, flt}, VEC[i][2:0]);
      end

      // R2: exact request latency
      idle_inputs();
      tick(6);
      br = 1;
      tick(2);
      check("R2", {grant, tri_o, flt}, 3'b000);
      tick(1);
      check("R2", {grant, tri_o, flt}, 3'b100);

      // R6: ack seen, grant falls three edges after ack drive
      br = 0; bgack = 1; as_i = 1;
      tick(2);
      check("R6", {grant, tri_o, flt}, 3'b100);
      tick(1);
      check("R6", {grant, tri_o, flt}, 3'b010);

      // R7: float one edge after strobe drops
      tick(3);
      check("R7", {grant, tri_o, flt}, 3'b010);
      as_i = 0;
      tick(1);
      check("R7", {grant, tri_o, flt}, 3'b011);

      // R8: tristate falls, float follows one clock later
      bgack = 0;
      tick(3);
      check("R8", {grant, tri_o, flt}, 3'b001);
      tick(1);
      check("R8", {grant, tri_o, flt}, 3'b000);

      // R3: grant on the edge closing the final cycle
      xfer = 1; last = 0; br = 1;
      tick(6);
      check("R3", {grant, tri_o, flt}, 3'b000);
      last = 1;
      tick(1);
      check("R3", {grant, tri_o, flt}, 3'b100);
      xfer = 0; last = 0;

      // R10: withdraw before ack never floats
      br = 0;
      tick(3);
      check("R10", {grant, tri_o, flt}, 3'b000);
      tick(1);
      check("R10", {grant, tri_o, flt}, 3'b000);

      // R5: show mode 01 over a long window
      show = 2'b01; br = 1;
      tick(20);
      check("R5", {grant, tri_o, flt}, 3'b000);
      show = 2'b11;
      tick(1);
      check("R5", {grant, tri_o, flt}, 3'b100);

      // R4: lock raised while requesting holds the next grant
      br = 0;
      tick(6);
      rmw = 1; br = 1;
      tick(10);
      check("R4", {grant, tri_o, flt}, 3'b000);

      // R9: requeued grant keeps tristate high throughout
      rmw = 0;
      tick(6);
      bgack = 1;
      tick(6);
      check("R9", {grant, tri_o, flt}, 3'b011);
      bgack = 0;
      tick(2);
      check("R9", {grant, tri_o, flt}, 3'b011);
      tick(1);
      check("R9", {grant, tri_o, flt}, 3'b111);

      idle_inputs();
      tick(4);
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

endmodule